// File: doc/BRIEF.md
# Management Interface PHY-Side Register Slave

This block is the PHY end of a two-wire, bit-banged management link. A host toggles a management clock level and drives a data bit together with an output-enable bit. The block runs on its own system clock. It detects each low-to-high change of the management clock level and shifts one received bit into a history window on that change.

Thirty-two consecutive received ones form a synchronisation run. After the run, a 16-bit command header is decoded. A valid read command streams a 16-bit register value back to the host on the data-in line, most significant bit first. A valid write command captures the next 16 received bits and stores them into a 32-entry by 16-bit register file. Two entries of the register file hold a fixed identifier. They are preset on reset, and writes to them are discarded.

The block is used behind a software-driven pin interface. Each host register access moves the clock, data or enable level, and the block acts only when the clock level rises.

Top module: `mgmt_phy_slave`

## Requirements
- R1: The bit taken on a rising edge of the management clock level is 1 only when both `host_dout_i` and `host_oe_i` are 1. With `host_oe_i` low the bit is 0, whatever `host_dout_i` is.
- R2: When the last 32 received bits are all ones, a frame counter is loaded with 32 and then drops by one per rising edge. The header is decoded on the 16th rising edge after the run. With only 31 ones before the header, no command is decoded. A run longer than 32 ones still works.
- R3: Header field positions, where bit 15 is received first: start is bits 15:14, opcode is bits 13:12, PHY address is bits 11:7, register address is bits 6:2 and turnaround is bits 1:0. The PHY address is not compared, so any PHY address is accepted.
- R4: A write is accepted only with start 01, opcode 01 and turnaround 10. A read is accepted with start 01, opcode 10 and turnaround bit 0 equal to 0. Any other header leaves the block idle: nothing is stored and `host_din_o` does not change.
- R5: For an accepted read, the addressed register is captured at header decode. Each of the next 16 rising edges then puts one bit on `host_din_o`, MSB first. The bit is visible from the second system clock edge after the level rises. `host_din_o` is 0 after reset.
- R6: For an accepted write, on the 16th rising edge after the header, the 16 bits received since the header are stored at the decoded register address. The block is then idle.
- R7: Writes to register 2 and register 3 are discarded, so those entries keep their identifier values.
- R8: `host_din_o` changes only on a rising edge of the management clock level. A falling edge, a held clock level, and changes of `host_dout_i` or `host_oe_i` leave it unchanged.
- R9: After reset, every register reads 0x0000 except register 2, which reads 0x0022, and register 3, which reads 0x161A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_lvl_i | input | 1 | Management clock level set by the host |
| host_dout_i | input | 1 | Host data-out level |
| host_oe_i | input | 1 | Host output-enable level |
| host_din_o | output | 1 | Data-in bit that the host reads back |

## Verification
The checker assumes that the management clock level is a clean host-written level that is held for at least one system clock between changes. Under that assumption, every rise is seen as exactly one edge event, and the frame counter and read shift step once per host clock pulse. The bench holds each level for several system clocks before changing it. It changes data and enable only while the clock level is low, so every sampled bit is unambiguous. Between transactions the bench sends zeros, so each new synchronisation run starts from a known history.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_W = 16;
  localparam int HIST_W  = 2 * FRAME_W;
  localparam int CNT_W   = $clog2(HIST_W + 1);
  localparam int RADDR_W = 5;
  localparam int PADDR_W = 5;
  localparam int REG_CNT = 1 << RADDR_W;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xact_e;

  typedef struct packed {
    logic [1:0]         st;
    logic [1:0]         op;
    logic [PADDR_W-1:0] phy;
    logic [RADDR_W-1:0] rad;
    logic [1:0]         ta;
  } hdr_t;

  function automatic hdr_t split_hdr(input logic [FRAME_W-1:0] w);
    return hdr_t'(w);
  endfunction

  function automatic xact_e classify(input hdr_t h);
    if (h.st == 2'b01 && h.op == 2'b01 && h.ta == 2'b10) return XS_WRITE;
    if (h.st == 2'b01 && h.op == 2'b10 && !h.ta[0])      return XS_READ;
    return XS_IDLE;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

endpackage

// File: rtl/mgmt_edge_detect.sv
module mgmt_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = rst_n && lvl_i && !prev_q;
endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile #(
  parameter int          AW      = 5,
  parameter int          DW      = 16,
  parameter int          FIXA    = 2,
  parameter logic [15:0] FIXA_V  = 16'h0022,
  parameter int          FIXB    = 3,
  parameter logic [15:0] FIXB_V  = 16'h161A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH*DW-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == FIXA || i == FIXB) begin : g_fixed
      // identifier entries: constant, writes never reach them
      localparam logic [DW-1:0] KVAL = (i == FIXA) ? DW'(FIXA_V) : DW'(FIXB_V);
      assign flat[i*DW +: DW] = KVAL;
    end else begin : g_rw
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          ent_q <= '0;
        else if (wr_en_i && wr_addr_i == AW'(i))
          ent_q <= wr_data_i;
      end
      assign flat[i*DW +: DW] = ent_q;
    end
  end

  assign rd_data_o = flat[rd_addr_i*DW +: DW];
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_i,
  input  logic               bit_i,
  input  logic [FRAME_W-1:0] rd_data_i,
  output logic [RADDR_W-1:0] rd_addr_o,
  output logic               wr_en_o,
  output logic [RADDR_W-1:0] wr_addr_o,
  output logic [FRAME_W-1:0] wr_data_o,
  output logic               din_o,
  output logic               sync_hit_o,
  output logic               hdr_strobe_o,
  output logic [CNT_W-1:0]   cnt_o,
  output xact_e              state_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HIST_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_W);

  logic [HIST_W-1:0]  hist_q, hist_n;
  logic [CNT_W-1:0]   cnt_q, cnt_eff;
  xact_e              state_q, state_mid;
  logic [RADDR_W-1:0] rad_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               din_q;
  hdr_t               hdr;
  xact_e              kind;
  logic               shift_evt, end_evt;

  assign hist_n     = {hist_q[HIST_W-2:0], bit_i};
  assign sync_hit_o = rise_i && (hist_n == '1);
  assign cnt_eff    = sync_hit_o ? CNT_FULL : cnt_q;
  assign hdr        = split_hdr(hist_n[FRAME_W-1:0]);
  assign kind       = classify(hdr);

  assign hdr_strobe_o = rise_i && (cnt_eff == CNT_HDR);
  assign state_mid    = hdr_strobe_o ? kind : state_q;
  assign shift_evt    = rise_i && (cnt_eff < CNT_HDR) && (state_mid == XS_READ);
  assign end_evt      = rise_i && (cnt_eff == '0) && (state_mid != XS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q  <= '0;
      cnt_q   <= '0;
      state_q <= XS_IDLE;
      rad_q   <= '0;
      shreg_q <= '0;
      din_q   <= 1'b0;
    end else if (rise_i) begin
      hist_q <= hist_n;
      cnt_q  <= step_down(cnt_eff);
      if (hdr_strobe_o && kind != XS_IDLE) rad_q <= hdr.rad;
      if (hdr_strobe_o && kind == XS_READ) shreg_q <= rd_data_i;
      if (shift_evt) begin
        din_q   <= shreg_q[FRAME_W-1];
        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
      end
      state_q <= end_evt ? XS_IDLE : state_mid;
    end
  end

  assign rd_addr_o = hdr.rad;
  assign wr_en_o   = end_evt && (state_mid == XS_WRITE);
  assign wr_addr_o = rad_q;
  assign wr_data_o = hist_n[FRAME_W-1:0];
  assign din_o     = din_q;
  assign cnt_o     = cnt_q;
  assign state_o   = state_q;
endmodule

// File: rtl/mgmt_phy_slave.sv
module mgmt_phy_slave
  import mgmt_pkg::*;
#(
  parameter int          ID_HI_IDX = 2,
  parameter logic [15:0] ID_HI_VAL = 16'h0022,
  parameter int          ID_LO_IDX = 3,
  parameter logic [15:0] ID_LO_VAL = 16'h161A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_lvl_i,
  input  logic host_dout_i,
  input  logic host_oe_i,
  output logic host_din_o
);
  logic               rise_evt;
  logic               rx_bit;
  logic [RADDR_W-1:0] rd_addr, wr_addr;
  logic [FRAME_W-1:0] rd_data, wr_data;
  logic               wr_commit;
  logic               sync_hit, hdr_strobe;
  logic [CNT_W-1:0]   frame_cnt;
  xact_e              xstate;

  assign rx_bit = host_dout_i & host_oe_i;

  mgmt_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (mdc_lvl_i),
    .rise_o (rise_evt)
  );

  mgmt_frame_engine u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_i       (rise_evt),
    .bit_i        (rx_bit),
    .rd_data_i    (rd_data),
    .rd_addr_o    (rd_addr),
    .wr_en_o      (wr_commit),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .din_o        (host_din_o),
    .sync_hit_o   (sync_hit),
    .hdr_strobe_o (hdr_strobe),
    .cnt_o        (frame_cnt),
    .state_o      (xstate)
  );

  mgmt_regfile #(
    .AW     (RADDR_W),
    .DW     (FRAME_W),
    .FIXA   (ID_HI_IDX),
    .FIXA_V (ID_HI_VAL),
    .FIXB   (ID_LO_IDX),
    .FIXB_V (ID_LO_VAL)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_commit),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/mgmt_phy_slave_chk.sv
module mgmt_phy_slave_chk
  import mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rise_evt,
  input logic             sync_hit,
  input logic             hdr_strobe,
  input logic             wr_commit,
  input logic [CNT_W-1:0] frame_cnt,
  input xact_e            xstate,
  input logic             host_din_o
);
  // R8: data-in moves only on a rising clock level
  p_din_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(host_din_o));

  // R2: a sync run reloads the counter, which then steps down
  p_sync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && sync_hit) |=> (frame_cnt == CNT_W'(HIST_W - 1)));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !sync_hit && frame_cnt != '0) |=> (frame_cnt == $past(frame_cnt) - 1'b1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(frame_cnt));

  // R3: the header is framed exactly at the mid mark
  p_hdr_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_strobe |-> (!sync_hit && frame_cnt == CNT_W'(FRAME_W)));

  // R6: a store happens only at the end of a write, and the block then idles
  p_wr_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (frame_cnt == '0 && xstate == XS_WRITE));

  p_idle_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !sync_hit && frame_cnt == '0) |=> (xstate == XS_IDLE));
endmodule

bind mgmt_phy_slave mgmt_phy_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rise_evt   (rise_evt),
  .sync_hit   (sync_hit),
  .hdr_strobe (hdr_strobe),
  .wr_commit  (wr_commit),
  .frame_cnt  (frame_cnt),
  .xstate     (xstate),
  .host_din_o (host_din_o)
);

// File: tb/mgmt_phy_slave_test.sv
module mgmt_phy_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0, dout = 1'b0, oe = 1'b0;
  logic din;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mgmt_phy_slave uut (
    .clk(clk), .rst_n(rst_n), .mdc_lvl_i(mdc),
    .host_dout_i(dout), .host_oe_i(oe), .host_din_o(din)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one management clock pulse; returns data-in after the rise
  task automatic pulse(input logic d, input logic e, output logic seen);
    @(negedge clk); dout = d; oe = e; mdc = 1'b0;
    repeat (2) @(negedge clk);
    mdc = 1'b1;
    repeat (3) @(negedge clk);
    seen = din;
    mdc = 1'b0;
  endtask

  task automatic xact(input int pre, input logic [15:0] hdr, input logic ta_oe,
                      input logic [15:0] data, input logic data_oe,
                      output logic [15:0] cap);
    logic s;
    for (int i = 0; i < 8; i++) pulse(1'b0, 1'b1, s);
    for (int i = 0; i < pre; i++) pulse(1'b1, 1'b1, s);
    for (int i = 15; i >= 2; i--) pulse(hdr[i], 1'b1, s);
    for (int i = 1; i >= 0; i--) pulse(hdr[i], ta_oe, s);
    cap = '0;
    for (int i = 15; i >= 0; i--) begin
      pulse(data[i], data_oe, s);
      cap = {cap[14:0], s};
    end
  endtask

  function automatic logic [15:0] rd_hdr(input logic [4:0] phy, input logic [4:0] ra);
    return {2'b01, 2'b10, phy, ra, 2'b00};
  endfunction
  function automatic logic [15:0] wr_hdr(input logic [4:0] phy, input logic [4:0] ra);
    return {2'b01, 2'b01, phy, ra, 2'b10};
  endfunction

  task automatic read_reg(input logic [4:0] ra, output logic [15:0] v);
    xact(32, rd_hdr(5'd1, ra), 1'b0, 16'h0000, 1'b0, v);
  endtask
  task automatic write_reg(input logic [4:0] ra, input logic [15:0] v);
    logic [15:0] c;
    xact(32, wr_hdr(5'd1, ra), 1'b1, v, 1'b1, c);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R5 din after reset", {15'd0, din}, 16'h0000);
    read_reg(5'd2, v);  check("R9 reg2 id", v, 16'h0022);
    read_reg(5'd3, v);  check("R9 reg3 id", v, 16'h161A);
    read_reg(5'd0, v);  check("R9 reg0 zero", v, 16'h0000);
    read_reg(5'd31, v); check("R9 reg31 zero", v, 16'h0000);
  endtask

  task automatic t_write_read;
    logic [15:0] v;
    write_reg(5'd7, 16'hA5C3);
    read_reg(5'd7, v); check("R5 R6 reg7 round trip", v, 16'hA5C3);
    xact(32, wr_hdr(5'h1F, 5'd31), 1'b1, 16'h8001, 1'b1, v);
    xact(32, rd_hdr(5'h00, 5'd31), 1'b0, 16'h0000, 1'b0, v);
    check("R3 reg31 any phy", v, 16'h8001);
    read_reg(5'd7, v); check("R6 reg7 untouched by reg31 write", v, 16'hA5C3);
  endtask

  task automatic t_id_locked;
    logic [15:0] v;
    write_reg(5'd2, 16'hFFFF);
    read_reg(5'd2, v); check("R7 reg2 write discarded", v, 16'h0022);
    write_reg(5'd3, 16'h0000);
    read_reg(5'd3, v); check("R7 reg3 write discarded", v, 16'h161A);
  endtask

  task automatic t_oe_gate;
    logic [15:0] v;
    write_reg(5'd9, 16'hBEEF);
    xact(32, wr_hdr(5'd1, 5'd9), 1'b1, 16'hFFFF, 1'b0, v);
    read_reg(5'd9, v); check("R1 data with oe low stores zero", v, 16'h0000);
  endtask

  task automatic t_bad_headers;
    logic [15:0] v;
    write_reg(5'd10, 16'h1234);
    xact(32, {2'b00, 2'b01, 5'd1, 5'd10, 2'b10}, 1'b1, 16'hFFFF, 1'b1, v);
    read_reg(5'd10, v); check("R4 bad start ignored", v, 16'h1234);
    xact(32, {2'b01, 2'b01, 5'd1, 5'd10, 2'b11}, 1'b1, 16'h5555, 1'b1, v);
    read_reg(5'd10, v); check("R4 write bad turnaround ignored", v, 16'h1234);
    read_reg(5'd7, v);  // leaves din at 1 (LSB of 0xA5C3)
    xact(32, {2'b01, 2'b10, 5'd1, 5'd0, 2'b01}, 1'b1, 16'h0000, 1'b0, v);
    check("R4 read bad turnaround keeps din", v, 16'hFFFF);
  endtask

  task automatic t_sync_len;
    logic [15:0] v;
    write_reg(5'd12, 16'h0F0F);
    xact(31, wr_hdr(5'd1, 5'd12), 1'b1, 16'h7777, 1'b1, v);
    read_reg(5'd12, v); check("R2 31 ones no sync", v, 16'h0F0F);
    xact(40, wr_hdr(5'd1, 5'd12), 1'b1, 16'h7777, 1'b1, v);
    xact(45, rd_hdr(5'd1, 5'd12), 1'b0, 16'h0000, 1'b0, v);
    check("R2 long preamble works", v, 16'h7777);
  endtask

  task automatic t_din_hold;
    logic [15:0] v;
    read_reg(5'd7, v);
    check("R5 din ends with LSB", {15'd0, din}, 16'h0001);
    @(negedge clk); dout = 1'b0; oe = 1'b1;
    repeat (3) @(negedge clk); dout = 1'b1; oe = 1'b0;
    repeat (3) @(negedge clk); mdc = 1'b1;
    repeat (3) @(negedge clk); mdc = 1'b0;   // only one rise, idle state
    repeat (3) @(negedge clk);
    check("R8 din unchanged by fall and data toggles", {15'd0, din}, 16'h0001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_write_read;
    t_id_locked;
    t_oe_gate;
    t_bad_headers;
    t_sync_len;
    t_din_hold;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule